// File: doc/BRIEF.md
# Outstanding Cache Request Tracker

This block sits between a processor-side request port and a cache controller and keeps a record of every memory request still in flight. Each request is tracked by cache line. Plain loads and instruction fetches go into a read table. Stores, read-modify-write halves and locked accesses go into a separate write table. A new request is refused when its line is already in flight in either table, or when the tracker has no room for it. Each accepted request gets a sequential identifier and is passed downstream as a translated command.

A load-linked / store-conditional reservation is held for one line at a time. A completed locked read takes the reservation for its requester. A locked write is let through only if that same requester still holds the reservation on that line. When a completion arrives, its entry is released and the number of cycles the entry was outstanding is reported. A watchdog checks the age of every live entry at a fixed interval and latches a fatal flag if any entry has been outstanding too long.

Top module: `line_req_tracker`

## Requirements
- R1: Request kinds are encoded as load=0, fetch=1, store=2, rmw-read=3, rmw-write=4, locked-read=5, locked-write=6. Kinds 2..6 are held in the write table and kinds 0..1 in the read table. A completion releases only an entry in the table chosen by `cpl_write` (1 = write table).
- R2: The line address is the request address with its low log2(BLK_BYTES) bits dropped, and `dn_line` carries it. A request whose in-line offset plus `req_len` exceeds BLK_BYTES is refused with code 4 and issues nothing.
- R3: A request whose line has a write-table entry is refused with code 1 (alias), and this test takes precedence over all others except R2. A request whose line has a read-table entry is also refused with code 1. Any offset within the line counts.
- R4: A request that does not alias is refused with code 2 (full) when the number of entries in both tables together is at least MAX_OUT, or when its own table has no free entry.
- R5: Each alias refusal increments exactly one of four counters. A write-table hit counts in `stl_wr_rd` when the incoming kind is 0, 1 or 3, and in `stl_wr_wr` otherwise. A read-table hit counts in `stl_rd_wr` when the incoming kind is 2 or 4, and in `stl_rd_rd` otherwise.
- R6: A locked-write from a requester that does not hold the reservation on its line is refused with code 3. It issues nothing, allocates no entry and consumes no identifier. When the requester does hold the reservation, the locked-write is accepted and the reservation is cleared.
- R7: When a locked-read completes, the reservation is set to that line and to the `req_src` of the locked-read. A locked-write from any other requester then fails.
- R8: The downstream command is fetch=0, load=1, store=2, and 3 for every rmw and locked kind. `dn_supv` is 1 only for mode 1 (supervisor). Modes 0 (user) and 2 (device) are sent as user.
- R9: An accepted request answers with code 0 and an identifier one greater than the previous accepted request's, starting at 0 after reset. The response and the downstream issue appear in the cycle after the request is sampled.
- R10: While entries are outstanding, the watchdog compares each entry's age with DL_THRESH every DL_PERIOD cycles. It sets `deadlock` if any age is at or above DL_THRESH, and `deadlock` then stays set until reset.
- R11: A matching completion pulses `done_valid` with the entry's identifier and kind in the next cycle. `lat_cycles` is the sampling cycle of the completion minus the sampling cycle of the request, and `lat_valid` is raised only when that value is nonzero.
- R12: A completion that matches no valid entry in the selected table pulses `cpl_err` in the next cycle, raises no `done_valid` and leaves both tables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Request kind (R1 encoding) |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | LEN_W | Access length in bytes |
| req_mode | input | 2 | Access mode: 0 user, 1 supervisor, 2 device |
| req_src | input | SRC_W | Requester identifier |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_code | output | 3 | 0 ok, 1 alias, 2 full, 3 conditional fail, 4 span |
| rsp_id | output | ID_W | Identifier assigned on accept, else 0 |
| dn_valid | output | 1 | Downstream command valid |
| dn_cmd | output | 2 | Downstream command code |
| dn_line | output | ADDR_W-log2(BLK_BYTES) | Line address |
| dn_supv | output | 1 | Supervisor mode flag |
| dn_id | output | ID_W | Identifier of issued request |
| cpl_valid | input | 1 | Completion present this cycle |
| cpl_write | input | 1 | Completion targets the write table |
| cpl_line | input | ADDR_W-log2(BLK_BYTES) | Completed line address |
| done_valid | output | 1 | Completion matched an entry |
| done_id | output | ID_W | Identifier of released entry |
| done_kind | output | 3 | Kind of released entry |
| lat_valid | output | 1 | Nonzero latency reported |
| lat_cycles | output | TS_W | Cycles the entry was outstanding |
| cpl_err | output | 1 | Completion matched nothing |
| deadlock | output | 1 | Sticky age-limit violation |
| stl_wr_rd | output | STALL_W | Read-like request blocked by write entry |
| stl_wr_wr | output | STALL_W | Other request blocked by write entry |
| stl_rd_wr | output | STALL_W | Store-like request blocked by read entry |
| stl_rd_rd | output | STALL_W | Other request blocked by read entry |

## Verification
The bench builds the tracker with four entries per table and MAX_OUT=6. With these values the shared limit can be hit with both tables partly filled, and the per-table limit can be hit by four stores while the total is still under the shared limit. BLK_BYTES=64 allows a 16-byte access at offset 48, which ends exactly on the block edge, to be compared against a 17-byte access, which crosses it. DL_THRESH=200 with DL_PERIOD=16 gives entries from the ordinary tests too little time to trip the watchdog, while a single entry deliberately left outstanding trips it within a bounded wait.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

   typedef enum logic [2:0] {
      RQ_LOAD   = 3'd0,
      RQ_FETCH  = 3'd1,
      RQ_STORE  = 3'd2,
      RQ_RMW_RD = 3'd3,
      RQ_RMW_WR = 3'd4,
      RQ_LL     = 3'd5,
      RQ_SC     = 3'd6
   } rq_kind_e;

   typedef enum logic [1:0] {
      DN_FETCH  = 2'd0,
      DN_LOAD   = 2'd1,
      DN_STORE  = 2'd2,
      DN_ATOMIC = 2'd3
   } dn_cmd_e;

   typedef enum logic [2:0] {
      RS_OK     = 3'd0,
      RS_ALIAS  = 3'd1,
      RS_FULL   = 3'd2,
      RS_SCFAIL = 3'd3,
      RS_SPAN   = 3'd4
   } rs_code_e;

   // kinds tracked in the write table
   function automatic logic in_write_table(input logic [2:0] k);
      return (k >= 3'd2) && (k <= 3'd6);
   endfunction

   // incoming kinds counted as read-like when blocked by a write entry
   function automatic logic read_like(input logic [2:0] k);
      return (k == RQ_LOAD) || (k == RQ_FETCH) || (k == RQ_RMW_RD);
   endfunction

   // incoming kinds counted as write-like when blocked by a read entry
   function automatic logic write_like(input logic [2:0] k);
      return (k == RQ_STORE) || (k == RQ_RMW_WR);
   endfunction

   function automatic dn_cmd_e to_cmd(input logic [2:0] k);
      dn_cmd_e c;
      case (k)
         RQ_FETCH:  c = DN_FETCH;
         RQ_STORE:  c = DN_STORE;
         RQ_RMW_RD, RQ_RMW_WR, RQ_LL, RQ_SC: c = DN_ATOMIC;
         default:   c = DN_LOAD;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/lrt_table.sv
module lrt_table #(
   parameter int DEPTH  = 4,
   parameter int LW     = 26,
   parameter int IDW    = 8,
   parameter int SRCW   = 4,
   parameter int TSW    = 16,
   parameter int THRESH = 64,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [LW-1:0]   look_line,
   output logic            look_hit,
   input  logic            alloc_en,
   input  logic [LW-1:0]   alloc_line,
   input  logic [2:0]      alloc_kind,
   input  logic [IDW-1:0]  alloc_id,
   input  logic [SRCW-1:0] alloc_src,
   input  logic [TSW-1:0]  now,
   input  logic            free_en,
   input  logic [LW-1:0]   free_line,
   output logic            free_hit,
   output logic [2:0]      free_kind,
   output logic [IDW-1:0]  free_id,
   output logic [SRCW-1:0] free_src,
   output logic [TSW-1:0]  free_ts,
   output logic [CW-1:0]   count,
   output logic            full,
   output logic            aged
);

   localparam int IXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DEPTH-1:0]           vld_q;
   logic [DEPTH-1:0][LW-1:0]   line_q;
   logic [DEPTH-1:0][2:0]      kind_q;
   logic [DEPTH-1:0][IDW-1:0]  id_q;
   logic [DEPTH-1:0][SRCW-1:0] src_q;
   logic [DEPTH-1:0][TSW-1:0]  ts_q;

   logic [DEPTH-1:0] look_m, free_m, old_m, slot_oh;
   logic [IXW-1:0]   free_ix;

   for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
      assign look_m[e] = vld_q[e] && (line_q[e] == look_line);
      assign free_m[e] = vld_q[e] && (line_q[e] == free_line);
      assign old_m[e]  = vld_q[e] && ((now - ts_q[e]) >= TSW'(THRESH));
   end

   assign look_hit = |look_m;
   assign free_hit = |free_m;
   assign aged     = |old_m;
   assign full     = (count == CW'(DEPTH));

   // lowest free slot, one-hot
   always_comb begin
      slot_oh = '0;
      for (int e = DEPTH - 1; e >= 0; e--) begin
         if (!vld_q[e]) slot_oh = DEPTH'(1) << e;
      end
   end

   always_comb begin
      free_ix = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (free_m[e]) free_ix = IXW'(e);
      end
   end

   always_comb begin
      count = '0;
      for (int e = 0; e < DEPTH; e++) count = count + CW'(vld_q[e]);
   end

   assign free_kind = kind_q[free_ix];
   assign free_id   = id_q[free_ix];
   assign free_src  = src_q[free_ix];
   assign free_ts   = ts_q[free_ix];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= '0;
         line_q <= '0;
         kind_q <= '0;
         id_q   <= '0;
         src_q  <= '0;
         ts_q   <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (alloc_en && slot_oh[e]) begin
               vld_q[e]  <= 1'b1;
               line_q[e] <= alloc_line;
               kind_q[e] <= alloc_kind;
               id_q[e]   <= alloc_id;
               src_q[e]  <= alloc_src;
               ts_q[e]   <= now;
            end else if (free_en && free_m[e]) begin
               vld_q[e] <= 1'b0;
            end
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> !full); // R4

   AST_LINE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(look_m)); // R3

   AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (free_en && !free_hit && !alloc_en) |=> (count == $past(count))); // R12

endmodule

// File: rtl/lrt_resv.sv
module lrt_resv #(
   parameter int LW   = 26,
   parameter int SRCW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_en,
   input  logic [LW-1:0]   set_line,
   input  logic [SRCW-1:0] set_src,
   input  logic            clr_en,
   input  logic [LW-1:0]   chk_line,
   input  logic [SRCW-1:0] chk_src,
   output logic            own
);

   logic            vld_q;
   logic [LW-1:0]   line_q;
   logic [SRCW-1:0] src_q;

   assign own = vld_q && (line_q == chk_line) && (src_q == chk_src);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         line_q <= '0;
         src_q  <= '0;
      end else if (set_en) begin
         vld_q  <= 1'b1;
         line_q <= set_line;
         src_q  <= set_src;
      end else if (clr_en) begin
         vld_q <= 1'b0;
      end
   end

   AST_RSV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en) |=> !vld_q); // R6

   AST_RSV_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> (vld_q && line_q == $past(set_line))); // R7

endmodule

// File: rtl/lrt_watchdog.sv
module lrt_watchdog #(
   parameter int PERIOD = 64,
   localparam int PW    = $clog2(PERIOD + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic aged,
   output logic deadlock
);

   logic [PW-1:0] tick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q   <= '0;
         deadlock <= 1'b0;
      end else if (!busy) begin
         tick_q <= '0;
      end else if (tick_q == PW'(PERIOD - 1)) begin
         tick_q <= '0;
         if (aged) deadlock <= 1'b1;
      end else begin
         tick_q <= tick_q + 1'b1;
      end
   end

   AST_DEADLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      deadlock |=> deadlock); // R10

endmodule

// File: rtl/line_req_tracker.sv
module line_req_tracker
   import lrt_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int BLK_BYTES = 64,
   parameter int LEN_W     = 7,
   parameter int RD_DEPTH  = 4,
   parameter int WR_DEPTH  = 4,
   parameter int MAX_OUT   = 6,
   parameter int ID_W      = 8,
   parameter int SRC_W     = 4,
   parameter int TS_W      = 16,
   parameter int DL_THRESH = 64,
   parameter int DL_PERIOD = 64,
   parameter int STALL_W   = 16
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   req_valid,
   input  logic [2:0]                             req_kind,
   input  logic [ADDR_W-1:0]                      req_addr,
   input  logic [LEN_W-1:0]                       req_len,
   input  logic [1:0]                             req_mode,
   input  logic [SRC_W-1:0]                       req_src,
   output logic                                   rsp_valid,
   output logic [2:0]                             rsp_code,
   output logic [ID_W-1:0]                        rsp_id,
   output logic                                   dn_valid,
   output logic [1:0]                             dn_cmd,
   output logic [ADDR_W-$clog2(BLK_BYTES)-1:0]    dn_line,
   output logic                                   dn_supv,
   output logic [ID_W-1:0]                        dn_id,
   input  logic                                   cpl_valid,
   input  logic                                   cpl_write,
   input  logic [ADDR_W-$clog2(BLK_BYTES)-1:0]    cpl_line,
   output logic                                   done_valid,
   output logic [ID_W-1:0]                        done_id,
   output logic [2:0]                             done_kind,
   output logic                                   lat_valid,
   output logic [TS_W-1:0]                        lat_cycles,
   output logic                                   cpl_err,
   output logic                                   deadlock,
   output logic [STALL_W-1:0]                     stl_wr_rd,
   output logic [STALL_W-1:0]                     stl_wr_wr,
   output logic [STALL_W-1:0]                     stl_rd_wr,
   output logic [STALL_W-1:0]                     stl_rd_rd
);

   localparam int OFF_W  = $clog2(BLK_BYTES);
   localparam int LINE_W = ADDR_W - OFF_W;
   localparam int RCW    = $clog2(RD_DEPTH + 1);
   localparam int WCW    = $clog2(WR_DEPTH + 1);
   localparam int TOT_W  = $clog2(RD_DEPTH + WR_DEPTH + 1);

   // elaboration-time parameter checks
   if (BLK_BYTES < 2 || (BLK_BYTES & (BLK_BYTES - 1)) != 0) begin : g_bad_blk
      $error("BLK_BYTES must be a power of two of at least 2");
   end
   if (MAX_OUT < 1 || MAX_OUT > RD_DEPTH + WR_DEPTH) begin : g_bad_max
      $error("MAX_OUT must lie between 1 and the sum of both depths");
   end
   if ((1 << LEN_W) <= BLK_BYTES) begin : g_bad_len
      $error("LEN_W must be wide enough to express a whole block");
   end
   if (DL_THRESH < 1 || DL_THRESH >= (1 << TS_W)) begin : g_bad_thr
      $error("DL_THRESH must fit below the timestamp range");
   end
   if (DL_PERIOD < 1) begin : g_bad_per
      $error("DL_PERIOD must be positive");
   end

   // ---------------- request decode ----------------
   logic [LINE_W-1:0] req_line;
   logic [OFF_W-1:0]  req_off;
   logic              span_bad, wcls, tot_full, tab_full, sc_own;
   logic              rd_hit, wr_hit, accept;
   rs_code_e          dec_code;

   assign req_line = req_addr[ADDR_W-1:OFF_W];
   assign req_off  = req_addr[OFF_W-1:0];
   assign span_bad = (int'(req_off) + int'(req_len)) > BLK_BYTES;
   assign wcls     = in_write_table(req_kind);

   logic [RCW-1:0]   rd_cnt;
   logic [WCW-1:0]   wr_cnt;
   logic [TOT_W-1:0] tot_cnt;
   logic             rd_full, wr_full, rd_aged, wr_aged;

   assign tot_cnt  = TOT_W'(rd_cnt) + TOT_W'(wr_cnt);
   assign tot_full = int'(tot_cnt) >= MAX_OUT;
   assign tab_full = wcls ? wr_full : rd_full;

   always_comb begin
      if (span_bad)                          dec_code = RS_SPAN;
      else if (wr_hit || rd_hit)             dec_code = RS_ALIAS;
      else if (tot_full || tab_full)         dec_code = RS_FULL;
      else if (req_kind == RQ_SC && !sc_own) dec_code = RS_SCFAIL;
      else                                   dec_code = RS_OK;
   end

   assign accept = req_valid && (dec_code == RS_OK);

   // ---------------- completion select ----------------
   logic              rd_fhit, wr_fhit, sel_hit, cpl_hit;
   logic [2:0]        rd_fkind, wr_fkind, sel_kind;
   logic [ID_W-1:0]   rd_fid, wr_fid, sel_id;
   logic [SRC_W-1:0]  rd_fsrc, wr_fsrc, sel_src;
   logic [TS_W-1:0]   rd_fts, wr_fts, sel_ts, lat_now;

   assign sel_hit  = cpl_write ? wr_fhit  : rd_fhit;
   assign sel_kind = cpl_write ? wr_fkind : rd_fkind;
   assign sel_id   = cpl_write ? wr_fid   : rd_fid;
   assign sel_src  = cpl_write ? wr_fsrc  : rd_fsrc;
   assign sel_ts   = cpl_write ? wr_fts   : rd_fts;
   assign cpl_hit  = cpl_valid && sel_hit;

   logic [TS_W-1:0] now_q;
   logic [ID_W-1:0] id_q;

   assign lat_now = now_q - sel_ts;

   // ---------------- tables ----------------
   lrt_table #(
      .DEPTH(RD_DEPTH), .LW(LINE_W), .IDW(ID_W), .SRCW(SRC_W),
      .TSW(TS_W), .THRESH(DL_THRESH)
   ) u_rd_tab (
      .clk(clk), .rst_n(rst_n),
      .look_line(req_line), .look_hit(rd_hit),
      .alloc_en(accept && !wcls), .alloc_line(req_line), .alloc_kind(req_kind),
      .alloc_id(id_q), .alloc_src(req_src), .now(now_q),
      .free_en(cpl_valid && !cpl_write), .free_line(cpl_line), .free_hit(rd_fhit),
      .free_kind(rd_fkind), .free_id(rd_fid), .free_src(rd_fsrc), .free_ts(rd_fts),
      .count(rd_cnt), .full(rd_full), .aged(rd_aged)
   );

   lrt_table #(
      .DEPTH(WR_DEPTH), .LW(LINE_W), .IDW(ID_W), .SRCW(SRC_W),
      .TSW(TS_W), .THRESH(DL_THRESH)
   ) u_wr_tab (
      .clk(clk), .rst_n(rst_n),
      .look_line(req_line), .look_hit(wr_hit),
      .alloc_en(accept && wcls), .alloc_line(req_line), .alloc_kind(req_kind),
      .alloc_id(id_q), .alloc_src(req_src), .now(now_q),
      .free_en(cpl_valid && cpl_write), .free_line(cpl_line), .free_hit(wr_fhit),
      .free_kind(wr_fkind), .free_id(wr_fid), .free_src(wr_fsrc), .free_ts(wr_fts),
      .count(wr_cnt), .full(wr_full), .aged(wr_aged)
   );

   lrt_resv #(.LW(LINE_W), .SRCW(SRC_W)) u_resv (
      .clk(clk), .rst_n(rst_n),
      .set_en(cpl_hit && sel_kind == RQ_LL), .set_line(cpl_line), .set_src(sel_src),
      .clr_en(accept && req_kind == RQ_SC),
      .chk_line(req_line), .chk_src(req_src), .own(sc_own)
   );

   lrt_watchdog #(.PERIOD(DL_PERIOD)) u_wdog (
      .clk(clk), .rst_n(rst_n),
      .busy((rd_cnt != '0) || (wr_cnt != '0)),
      .aged(rd_aged || wr_aged),
      .deadlock(deadlock)
   );

   // ---------------- registered outputs ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now_q      <= '0;
         id_q       <= '0;
         rsp_valid  <= 1'b0;
         rsp_code   <= '0;
         rsp_id     <= '0;
         dn_valid   <= 1'b0;
         dn_cmd     <= '0;
         dn_line    <= '0;
         dn_supv    <= 1'b0;
         dn_id      <= '0;
         done_valid <= 1'b0;
         done_id    <= '0;
         done_kind  <= '0;
         lat_valid  <= 1'b0;
         lat_cycles <= '0;
         cpl_err    <= 1'b0;
         stl_wr_rd  <= '0;
         stl_wr_wr  <= '0;
         stl_rd_wr  <= '0;
         stl_rd_rd  <= '0;
      end else begin
         now_q     <= now_q + 1'b1;
         rsp_valid <= req_valid;
         rsp_code  <= req_valid ? dec_code : RS_OK;
         rsp_id    <= accept ? id_q : '0;
         dn_valid  <= accept;
         dn_cmd    <= accept ? to_cmd(req_kind) : DN_FETCH;
         dn_line   <= accept ? req_line : '0;
         dn_supv   <= accept && (req_mode == 2'd1);
         dn_id     <= accept ? id_q : '0;
         if (accept) id_q <= id_q + 1'b1;

         if (req_valid && dec_code == RS_ALIAS) begin
            if (wr_hit) begin
               if (read_like(req_kind)) stl_wr_rd <= stl_wr_rd + 1'b1;
               else                     stl_wr_wr <= stl_wr_wr + 1'b1;
            end else begin
               if (write_like(req_kind)) stl_rd_wr <= stl_rd_wr + 1'b1;
               else                      stl_rd_rd <= stl_rd_rd + 1'b1;
            end
         end

         done_valid <= cpl_hit;
         done_id    <= cpl_hit ? sel_id : '0;
         done_kind  <= cpl_hit ? sel_kind : '0;
         lat_valid  <= cpl_hit && (lat_now != '0);
         lat_cycles <= cpl_hit ? lat_now : '0;
         cpl_err    <= cpl_valid && !sel_hit;
      end
   end

   AST_SPAN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && span_bad) |=> (rsp_code == RS_SPAN && !dn_valid)); // R2

   AST_ALIAS_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !span_bad && (wr_hit || rd_hit)) |=> (rsp_code == RS_ALIAS)); // R3

   AST_TOTAL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      int'(tot_cnt) <= MAX_OUT); // R4

   AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code != RS_OK) |-> !dn_valid); // R6

   AST_LAT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      lat_valid |-> (done_valid && lat_cycles != '0)); // R11

   AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_err |-> !done_valid); // R12

endmodule

// File: tb/sim_line_req_tracker.sv
module sim_line_req_tracker;

   localparam int AW = 32;
   localparam int LW = AW - 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_kind = '0;
   logic [AW-1:0] req_addr = '0;
   logic [6:0]    req_len = '0;
   logic [1:0]    req_mode = '0;
   logic [3:0]    req_src = '0;
   logic          cpl_valid = 1'b0;
   logic          cpl_write = 1'b0;
   logic [LW-1:0] cpl_line = '0;

   logic          rsp_valid, dn_valid, dn_supv, done_valid, lat_valid, cpl_err, deadlock;
   logic [2:0]    rsp_code, done_kind;
   logic [7:0]    rsp_id, dn_id, done_id;
   logic [1:0]    dn_cmd;
   logic [LW-1:0] dn_line;
   logic [15:0]   lat_cycles, stl_wr_rd, stl_wr_wr, stl_rd_wr, stl_rd_rd;

   int total = 0;
   int bad   = 0;
   int exp_id = 0;

   always #5 clk = ~clk;

   line_req_tracker #(
      .ADDR_W(AW), .BLK_BYTES(64), .LEN_W(7), .RD_DEPTH(4), .WR_DEPTH(4),
      .MAX_OUT(6), .ID_W(8), .SRC_W(4), .TS_W(16), .DL_THRESH(200),
      .DL_PERIOD(16), .STALL_W(16)
   ) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .req_len(req_len), .req_mode(req_mode), .req_src(req_src),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_id(rsp_id),
      .dn_valid(dn_valid), .dn_cmd(dn_cmd), .dn_line(dn_line),
      .dn_supv(dn_supv), .dn_id(dn_id),
      .cpl_valid(cpl_valid), .cpl_write(cpl_write), .cpl_line(cpl_line),
      .done_valid(done_valid), .done_id(done_id), .done_kind(done_kind),
      .lat_valid(lat_valid), .lat_cycles(lat_cycles), .cpl_err(cpl_err),
      .deadlock(deadlock),
      .stl_wr_rd(stl_wr_rd), .stl_wr_wr(stl_wr_wr),
      .stl_rd_wr(stl_rd_wr), .stl_rd_rd(stl_rd_rd)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // drive one request; outputs are sampled one negedge after the sampling edge
   task automatic send(input logic [2:0] k, input logic [31:0] a, input int ln,
                       input logic [1:0] m, input logic [3:0] s);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = a; req_len = 7'(ln);
      req_mode = m; req_src = s;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic cpl(input logic w, input logic [31:0] a);
      @(negedge clk);
      cpl_valid = 1'b1; cpl_write = w; cpl_line = LW'(a >> 6);
      @(negedge clk);
      cpl_valid = 1'b0;
   endtask

   // request expected to be accepted with the given command
   task automatic send_ok(input string tag, input logic [2:0] k, input logic [31:0] a,
                          input int ln, input logic [1:0] m, input logic [3:0] s,
                          input int cmd, input int supv);
      send(k, a, ln, m, s);
      chk({tag, " code"}, rsp_code, 0);
      chk({tag, " id"}, rsp_id, exp_id % 256);
      chk({tag, " dn_valid"}, dn_valid, 1);
      chk({tag, " dn_cmd"}, dn_cmd, cmd);
      chk({tag, " dn_line"}, dn_line, a >> 6);
      chk({tag, " dn_supv"}, dn_supv, supv);
      exp_id++;
   endtask

   task automatic send_rej(input string tag, input logic [2:0] k, input logic [31:0] a,
                           input int ln, input logic [3:0] s, input int code);
      send(k, a, ln, 2'd0, s);
      chk({tag, " code"}, rsp_code, code);
      chk({tag, " no issue"}, dn_valid, 0);
   endtask

   task automatic cpl_ok(input string tag, input logic w, input logic [31:0] a,
                         input int id, input int kind);
      cpl(w, a);
      chk({tag, " done"}, done_valid, 1);
      chk({tag, " id"}, done_id, id);
      chk({tag, " kind"}, done_kind, kind);
      chk({tag, " err"}, cpl_err, 0);
   endtask

   task automatic t_reset();
      chk("R9 reset rsp_valid", rsp_valid, 0);
      chk("R9 reset dn_valid", dn_valid, 0);
      chk("R10 reset deadlock", deadlock, 0);
      chk("R5 reset stall", stl_wr_rd + stl_wr_wr + stl_rd_wr + stl_rd_rd, 0);
   endtask

   task automatic t_issue();
      send_ok("R9 R8 R2 load user", 3'd0, 32'h1005, 4, 2'd0, 4'd1, 1, 0);
      send_ok("R8 fetch device", 3'd1, 32'h2000, 8, 2'd2, 4'd1, 0, 0);
      send_ok("R8 store supv", 3'd2, 32'h3000, 8, 2'd1, 4'd1, 2, 1);
      send_ok("R8 R1 rmw-read atomic", 3'd3, 32'h4000, 8, 2'd0, 4'd1, 3, 0);
   endtask

   task automatic t_alias();
      send_rej("R3 load on write line", 3'd0, 32'h3010, 4, 4'd1, 1);
      chk("R5 stl_wr_rd", stl_wr_rd, 1);
      send_rej("R3 store on read line", 3'd2, 32'h1020, 4, 4'd1, 1);
      chk("R5 stl_rd_wr", stl_rd_wr, 1);
      send_rej("R3 fetch on read line", 3'd1, 32'h1000, 4, 4'd1, 1);
      chk("R5 stl_rd_rd", stl_rd_rd, 1);
      send_rej("R3 rmw-write on write line", 3'd4, 32'h3000, 4, 4'd1, 1);
      chk("R5 stl_wr_wr", stl_wr_wr, 1);
      send_rej("R3 locked-read on read line", 3'd5, 32'h2004, 4, 4'd1, 1);
      chk("R5 stl_rd_rd second", stl_rd_rd, 2);
      chk("R5 stl_wr_rd unchanged", stl_wr_rd, 1);
   endtask

   task automatic t_full_total();
      send_ok("R4 fill 5", 3'd0, 32'h5000, 4, 2'd0, 4'd1, 1, 0);
      send_ok("R4 fill 6", 3'd2, 32'h6000, 4, 2'd0, 4'd1, 2, 0);
      send_rej("R4 total cap", 3'd0, 32'h7000, 4, 4'd1, 2);
   endtask

   task automatic t_complete();
      cpl(1'b1, 32'h1000);
      chk("R1 R12 wrong class err", cpl_err, 1);
      chk("R12 wrong class no done", done_valid, 0);
      cpl_ok("R1 R11 load done", 1'b0, 32'h1000, 0, 0);
      cpl(1'b0, 32'h1000);
      chk("R12 second completion err", cpl_err, 1);
      cpl(1'b0, 32'h4000);
      chk("R1 rmw-read not in read table", cpl_err, 1);
      cpl_ok("R1 rmw-read in write table", 1'b1, 32'h4000, 3, 3);
      cpl_ok("R11 fetch done", 1'b0, 32'h2000, 1, 1);
      cpl_ok("R11 store done", 1'b1, 32'h3000, 2, 2);
      cpl_ok("R11 load done 2", 1'b0, 32'h5000, 4, 0);
      cpl_ok("R11 store done 2", 1'b1, 32'h6000, 5, 2);
   endtask

   task automatic t_table_full();
      int base;
      base = exp_id;
      for (int i = 0; i < 4; i++)
         send_ok("R4 store fill", 3'd2, 32'h10000 + 32'(i) * 32'h40, 4, 2'd0, 4'd1, 2, 0);
      send_rej("R4 write table full", 3'd2, 32'h20000, 4, 4'd1, 2);
      send_ok("R4 read table still open", 3'd0, 32'h20000, 4, 2'd0, 4'd1, 1, 0);
      cpl_ok("R4 drain read", 1'b0, 32'h20000, base + 4, 0);
      for (int i = 0; i < 4; i++)
         cpl_ok("R4 drain store", 1'b1, 32'h10000 + 32'(i) * 32'h40, base + i, 2);
   endtask

   task automatic t_latency();
      int id;
      id = exp_id;
      send_ok("R11 lat issue", 3'd0, 32'h8000, 4, 2'd0, 4'd1, 1, 0);
      idle(4);
      cpl_ok("R11 lat done", 1'b0, 32'h8000, id, 0);
      chk("R11 lat_valid", lat_valid, 1);
      chk("R11 lat_cycles", lat_cycles, 6);
   endtask

   task automatic t_span();
      int id;
      id = exp_id;
      send_ok("R2 span exact edge", 3'd0, 32'h9030, 16, 2'd0, 4'd1, 1, 0);
      cpl_ok("R2 span drain", 1'b0, 32'h9000, id, 0);
      send_rej("R2 span crosses", 3'd0, 32'h9030, 17, 4'd1, 4);
   endtask

   task automatic t_resv();
      int id;
      send_rej("R6 sc without resv", 3'd6, 32'hA000, 4, 4'd1, 3);
      id = exp_id;
      send_ok("R6 no entry left by failed sc", 3'd0, 32'hA000, 4, 2'd0, 4'd1, 1, 0);
      cpl_ok("R6 drain", 1'b0, 32'hA000, id, 0);
      id = exp_id;
      send_ok("R7 locked-read", 3'd5, 32'hA008, 4, 2'd0, 4'd1, 3, 0);
      cpl_ok("R7 locked-read done", 1'b1, 32'hA000, id, 5);
      send_rej("R7 other src fails", 3'd6, 32'hA000, 4, 4'd2, 3);
      send_rej("R7 other line fails", 3'd6, 32'hB000, 4, 4'd1, 3);
      id = exp_id;
      send_ok("R6 R8 sc with resv", 3'd6, 32'hA010, 4, 2'd0, 4'd1, 3, 0);
      cpl_ok("R6 sc done", 1'b1, 32'hA000, id, 6);
      send_rej("R6 resv cleared", 3'd6, 32'hA000, 4, 4'd1, 3);
   endtask

   task automatic t_deadlock();
      int id;
      id = exp_id;
      send_ok("R10 stuck load", 3'd0, 32'hC000, 4, 2'd0, 4'd1, 1, 0);
      idle(150);
      chk("R10 below threshold", deadlock, 0);
      idle(100);
      chk("R10 above threshold", deadlock, 1);
      cpl_ok("R10 release", 1'b0, 32'hC000, id, 0);
      idle(20);
      chk("R10 sticky", deadlock, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_issue();
      t_alias();
      t_full_total();
      t_complete();
      t_table_full();
      t_latency();
      t_span();
      t_resv();
      chk("R10 no deadlock before stuck test", deadlock, 0);
      t_deadlock();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule